// File: doc/BRIEF.md
# External Memory Width Adapter

This block connects a 32-bit processor or DMA access port to external memory that may be 8, 16 or 32 bits wide. Data addresses fall into one of two strobe regions, chosen by the top address bit. Each region has its own run-time control register. One field in that register gives the physical width of the attached memory. A second field gives the width of the data items stored there. The two fields are independent.

When the data item is narrower than the memory, one bus cycle moves one slice of a memory word, and each slice has its own logical address. When the data item is wider than the memory, the access becomes two or four bus cycles at rising sub-addresses. Read data is gathered least significant part first. Narrow read results are returned zero-extended to 32 bits.

Each region drives a four-pin strobe set. Pins 0 and 1 are always byte enables. Pins 2 and 3 act as byte enables or as the two address bits below the word address, depending on the physical width.

A separate fetch request reads one 32-bit instruction from program memory. The program-width input pin chooses between one 32-bit fetch and two 16-bit fetches at consecutive halfword addresses.

Top module: `extmem_width_adapter`

## Requirements
- R1: After reset, no strobe, program chip select or write enable is active, `done` is low, and both regions are configured as 32-bit memory holding 32-bit data.
- R2: A data access with `addr[AW-1]`=0 drives only set `s0`, and one with `addr[AW-1]`=1 drives only set `s1`. A fetch drives only `prg_cs`. At most one of the three is active in any cycle.
- R3: With physical code 32, all four strobe pins are byte enables. Pin n enables bits 8n+7..8n, and the enabled lanes cover the addressed item. `ext_addr` is the 32-bit word address within the region.
- R4: With physical code 16, pins 0 and 1 enable the low and high byte of the halfword, pin 3 selects the halfword within the word, and pin 2 stays low.
- R5: With physical code 8, pin 0 is a chip enable that is high on every cycle, pin 1 stays low, and {pin 3, pin 2} give the byte index within the word.
- R6: When the data width is narrower than the physical width, item k occupies bytes k*D to k*D+D-1 of the little-endian byte space of the region, where D is the item size in bytes. A read returns the item zero-extended to 32 bits.
- R7: When the data width exceeds the physical width, an access takes D/P bus cycles, where D and P are the data and physical widths in bytes. The cycles run at rising sub-addresses, least significant part first. `done` pulses for one cycle, in the cycle after the last bus cycle.
- R8: A write changes only the bytes of the addressed item. Lanes whose enable is low carry zero on `ext_wdata`.
- R9: The width codes are 2'b00 for 8 bits, 2'b01 for 16 bits and 2'b10 for 32 bits. The code 2'b11 behaves as 32 bits.
- R10: With `prg_16` low, a fetch of word address a takes one cycle at `ext_addr`=a. With `prg_16` high, it takes two 16-bit cycles at halfword addresses 2a and 2a+1, with the first half giving the low 16 bits.
- R11: A control register write made between accesses applies to every later access in that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Region picked by the control write |
| cfg_phys | input | 2 | Physical width code |
| cfg_data | input | 2 | Data width code |
| prg_16 | input | 1 | Program memory is 16 bits wide when high |
| req | input | 1 | Start an access; ignored while one is running |
| fetch | input | 1 | The access is a program fetch |
| we | input | 1 | The data access is a write |
| addr | input | AW | Item address (data) or word address (fetch) |
| wdata | input | 32 | Write data, right aligned |
| done | output | 1 | One-cycle pulse when the access ends |
| rdata | output | 32 | Read result, valid with done |
| ext_addr | output | AW | External word or halfword address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |
| ext_we | output | 1 | External write enable |
| s0 | output | 4 | Strobe set of region 0 |
| s1 | output | 4 | Strobe set of region 1 |
| prg_cs | output | 1 | Program memory chip select |

## Verification
The assertions check these properties on every cycle:
- the strobe sets and the program select never overlap;
- everything is quiet while idle;
- pin 2 is low and pin 0 is high in the 16-bit and 8-bit pin roles;
- disabled write lanes carry zero;
- `done` is a single pulse that closes a bus sequence.

Other results come only from the bench scenarios against its byte-level memory model:
- the exact pin patterns and sub-address order of a split access;
- how read pieces are assembled;
- that a write leaves neighbouring bytes untouched;
- the effect of reserved codes and of reconfiguration at run time.

// File: rtl/extmem_width_adapter.sv
module extmem_width_adapter #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [1:0]    cfg_phys,
  input  logic [1:0]    cfg_data,
  input  logic          prg_16,
  input  logic          req,
  input  logic          fetch,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic [AW-1:0] ext_addr,
  output logic [31:0]   ext_wdata,
  input  logic [31:0]   ext_rdata,
  output logic          ext_we,
  output logic [3:0]    s0,
  output logic [3:0]    s1,
  output logic          prg_cs
);

  function automatic logic [1:0] lg(input logic [1:0] c);
    return (c == 2'b00) ? 2'd0 : (c == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  logic [1:0]    cp [2];
  logic [1:0]    cd [2];
  logic          busy, f_l, we_l, rs_l;
  logic [1:0]    lp, ld, cnt, last;
  logic [AW+1:0] base;
  logic [31:0]   wd_l, acc;

  wire [1:0]    nlp  = fetch ? (prg_16 ? 2'd1 : 2'd2) : lg(cp[addr[AW-1]]);
  wire [1:0]    nld  = fetch ? 2'd2 : lg(cd[addr[AW-1]]);
  wire [1:0]    nlst = (nld <= nlp) ? 2'd0 : (nld - nlp == 2'd1) ? 2'd1 : 2'd3;
  wire [AW+1:0] noff = fetch ? {addr, 2'b00} : ({3'b000, addr[AW-2:0]} << nld);

  wire [AW+1:0] cb   = base + ((AW+2)'(cnt) << lp);
  wire [1:0]    off  = cb[1:0];
  wire [1:0]    u    = (ld < lp) ? ld : lp;
  wire [1:0]    sh   = (lp == 2'd2) ? off : (lp == 2'd1) ? {1'b0, off[0]} : 2'b00;
  wire [31:0]   um   = (u == 2'd0) ? 32'h0000_00FF : (u == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  wire [5:0]    pos  = 6'({cnt, 3'b000}) << lp;
  wire [31:0]   pw   = ((wd_l >> pos) & um) << {sh, 3'b000};
  wire [31:0]   pr   = ((ext_rdata >> {sh, 3'b000}) & um) << pos;
  wire [3:0]    dm   = (ld == 2'd0) ? 4'b0001 : (ld == 2'd1) ? 4'b0011 : 4'b1111;

  logic [3:0] pins;
  always_comb begin
    case (lp)
      2'd2:    pins = dm << off;
      2'd1:    pins = {off[1], 1'b0, (ld == 2'd0) ? (off[0] ? 2'b10 : 2'b01) : 2'b11};
      default: pins = {off[1], off[0], 1'b0, 1'b1};
    endcase
  end

  wire dat = busy && !f_l;
  assign s0        = (dat && !rs_l) ? pins : 4'b0000;
  assign s1        = (dat &&  rs_l) ? pins : 4'b0000;
  assign prg_cs    = busy && f_l;
  assign ext_we    = dat && we_l;
  assign ext_wdata = ext_we ? pw : 32'h0;
  assign ext_addr  = !busy ? '0 : (f_l && lp == 2'd1) ? cb[AW:1] : cb[AW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp    <= '{2'b10, 2'b10};
      cd    <= '{2'b10, 2'b10};
      busy  <= 1'b0;
      f_l   <= 1'b0;
      we_l  <= 1'b0;
      rs_l  <= 1'b0;
      lp    <= 2'd2;
      ld    <= 2'd2;
      cnt   <= 2'd0;
      last  <= 2'd0;
      base  <= '0;
      wd_l  <= '0;
      acc   <= '0;
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= 1'b0;
      if (cfg_we) begin
        cp[cfg_sel] <= cfg_phys;
        cd[cfg_sel] <= cfg_data;
      end
      if (busy) begin
        acc <= acc | pr;
        cnt <= cnt + 2'd1;
        if (cnt == last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          rdata <= we_l ? 32'h0 : (acc | pr);
        end
      end else if (req) begin
        busy <= 1'b1;
        f_l  <= fetch;
        we_l <= we && !fetch;
        rs_l <= addr[AW-1];
        lp   <= nlp;
        ld   <= nld;
        last <= nlst;
        base <= noff;
        wd_l <= wdata;
        acc  <= '0;
        cnt  <= 2'd0;
      end
    end
  end

endmodule

module extmem_width_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        f_l,
  input logic [1:0]  lp,
  input logic [3:0]  s0,
  input logic [3:0]  s1,
  input logic        prg_cs,
  input logic        done,
  input logic        ext_we,
  input logic [31:0] ext_wdata
);
  wire [3:0] p = s0 | s1;

  AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|s0, |s1, prg_cs})); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (s0 == 4'b0 && s1 == 4'b0 && !prg_cs && !ext_we)); // R1
  AST_HALF_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !f_l && lp == 2'd1) |-> ((p & 4'b0100) == 4'b0)); // R4
  AST_BYTE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !f_l && lp == 2'd0) |-> ((p & 4'b0011) == 4'b0001)); // R5
  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && lp == 2'd2) |-> ((ext_wdata & ~{{8{p[3]}}, {8{p[2]}}, {8{p[1]}}, {8{p[0]}}}) == 32'h0)); // R8
  AST_DONE_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

bind extmem_width_adapter extmem_width_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .f_l(f_l), .lp(lp), .s0(s0), .s1(s1),
  .prg_cs(prg_cs), .done(done), .ext_we(ext_we), .ext_wdata(ext_wdata)
);

// File: tb/sim_extmem_width_adapter.sv
`timescale 1ns/1ps
module sim_extmem_width_adapter;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0, prg_16 = 0, req = 0, fetch = 0, we = 0;
  logic [1:0] cfg_phys = 0, cfg_data = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, ext_wdata, ext_rdata;
  logic [AW-1:0] ext_addr;
  logic done, ext_we, prg_cs;
  logic [3:0] s0, s1;

  always #10 clk = ~clk;

  extmem_width_adapter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_phys(cfg_phys),
    .cfg_data(cfg_data), .prg_16(prg_16), .req(req), .fetch(fetch), .we(we), .addr(addr),
    .wdata(wdata), .done(done), .rdata(rdata), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_we(ext_we), .s0(s0), .s1(s1), .prg_cs(prg_cs));

  int errors = 0, checks = 0;
  logic [7:0]  bm [2][256];
  logic [7:0]  sm [2][256];
  logic [15:0] phw [256];
  int          bp [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd();
    logic [31:0] v;
    int r;
    logic [3:0] p;
    logic [5:0] a;
    v = 0;
    if (prg_cs) begin
      if (prg_16) v = {16'h0, phw[ext_addr[7:0]]};
      else v = {phw[{ext_addr[6:0], 1'b1}], phw[{ext_addr[6:0], 1'b0}]};
    end else if (|s0 || |s1) begin
      r = (|s1) ? 1 : 0;
      p = r ? s1 : s0;
      a = ext_addr[5:0];
      case (bp[r])
        2: v = {bm[r][{a, 2'd3}], bm[r][{a, 2'd2}], bm[r][{a, 2'd1}], bm[r][{a, 2'd0}]};
        1: v = {16'h0, bm[r][{a, p[3], 1'b1}], bm[r][{a, p[3], 1'b0}]};
        default: v = {24'h0, bm[r][{a, p[3], p[2]}]};
      endcase
    end
    return v;
  endfunction
  always_comb ext_rdata = mrd();

  always @(posedge clk) begin
    if (ext_we) begin
      automatic int r = (|s1) ? 1 : 0;
      automatic logic [3:0] p = r ? s1 : s0;
      automatic logic [5:0] a = ext_addr[5:0];
      if (bp[r] == 2) begin
        for (int j = 0; j < 4; j++) if (p[j]) bm[r][{a, 2'(j)}] <= ext_wdata[8*j +: 8];
      end else if (bp[r] == 1) begin
        for (int j = 0; j < 2; j++) if (p[j]) bm[r][{a, p[3], 1'(j)}] <= ext_wdata[8*j +: 8];
      end else if (p[0]) bm[r][{a, p[3], p[2]}] <= ext_wdata[7:0];
    end
  end

  logic [31:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];
  logic [AW-1:0] la [4], last_a [4];
  logic [3:0]    lpn [4], last_p [4];
  logic [2:0]    lreg, last_reg;
  int            n = 0, last_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (|s0 || |s1 || prg_cs) begin
        if (n < 4) begin
          la[n] = ext_addr;
          lpn[n] = s0 | s1;
        end
        lreg = lreg | {prg_cs, |s1, |s0};
        n++;
      end
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected done", 32'(n), 0);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic int c = cyc_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(rdata == e, {t, " data"}, rdata, e);
          chk(n == c, {t, " bus cycles"}, 32'(n), 32'(c));
        end
        last_n = n;
        last_a = la;
        last_p = lpn;
        last_reg = lreg;
        n = 0;
        lreg = 0;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input int r, input int a, input int l);
    logic [31:0] v = 0;
    int b = (a << l) & 255;
    for (int i = 0; i < (1 << l); i++) v |= 32'(sm[r][(b + i) & 255]) << (8 * i);
    return v;
  endfunction

  task automatic cfg(input int r, input logic [1:0] p, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = r[0]; cfg_phys = p; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    bp[r] = (p == 2'b00) ? 0 : (p == 2'b01) ? 1 : 2;
  endtask

  task automatic go(input bit f, input bit w, input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [31:0] e, input int c, input string t);
    exp_q.push_back(e); cyc_q.push_back(c); tag_q.push_back(t);
    @(negedge clk);
    req = 1; fetch = f; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    for (int k = 0; k < 50 && !done; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4ms;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] e;
    for (int r = 0; r < 2; r++) begin
      bp[r] = 2;
      for (int i = 0; i < 256; i++) begin
        bm[r][i] = 8'(i * 7 + r * 64 + 3);
        sm[r][i] = bm[r][i];
      end
    end
    for (int i = 0; i < 256; i++) phw[i] = 16'(i * 16'h1357 + 16'h0102);
    lreg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!done && s0 == 0 && s1 == 0 && !prg_cs && !ext_we, "R1 idle outputs",
        {done, s0, s1, prg_cs, ext_we}, 0);

    // R1 default 32/32, R3 full word
    e = exp_rd(0, 5, 2);
    go(0, 0, 16'h0005, 0, e, 1, "R1 default config read");
    chk(last_p[0] == 4'b1111, "R3 pins full word", 32'(last_p[0]), 32'hF);
    chk(last_a[0] == 16'd5, "R3 word address", 32'(last_a[0]), 5);
    chk(last_reg == 3'b001, "R2 region0 only", 32'(last_reg), 1);

    // R6 R3 byte slice of 32-bit memory, zero-extended
    cfg(0, 2'b10, 2'b00);
    e = exp_rd(0, 6, 0);
    go(0, 0, 16'h0006, 0, e, 1, "R6 byte slice read");
    chk(last_p[0] == 4'b0100, "R3 lane of byte 2", 32'(last_p[0]), 32'h4);
    chk(last_a[0] == 16'd1, "R6 slice word address", 32'(last_a[0]), 1);
    chk(e[31:8] == 0, "R6 zero extension", e, e & 32'hFF);

    // R8 halfword write into 32-bit memory
    cfg(0, 2'b10, 2'b01);
    sm[0][6] = 8'hCD; sm[0][7] = 8'hAB;
    go(0, 1, 16'h0003, 32'hFFFF_ABCD, 0, 1, "R8 halfword write");
    chk(last_p[0] == 4'b1100, "R8 upper two lanes", 32'(last_p[0]), 32'hC);
    for (int i = 4; i < 8; i++) chk(bm[0][i] == sm[0][i], "R8 byte image", 32'(bm[0][i]), 32'(sm[0][i]));

    // R4 16-bit memory
    cfg(1, 2'b01, 2'b01);
    e = exp_rd(1, 3, 1);
    go(0, 0, 16'h8003, 0, e, 1, "R4 halfword read");
    chk(last_p[0] == 4'b1011, "R4 upper halfword pins", 32'(last_p[0]), 32'hB);
    chk(last_reg == 3'b010, "R2 region1 only", 32'(last_reg), 2);
    cfg(1, 2'b01, 2'b00);
    e = exp_rd(1, 5, 0);
    go(0, 0, 16'h8005, 0, e, 1, "R6 byte in 16-bit memory");
    chk(last_p[0] == 4'b0010, "R4 high byte lane", 32'(last_p[0]), 32'h2);
    chk(last_a[0] == 16'd1, "R4 word address", 32'(last_a[0]), 1);

    // R7 32-bit data from 16-bit memory
    cfg(1, 2'b01, 2'b10);
    e = exp_rd(1, 2, 2);
    go(0, 0, 16'h8002, 0, e, 2, "R7 two halfword cycles");
    chk(last_p[0] == 4'b0011 && last_p[1] == 4'b1011, "R7 halfword order",
        {last_p[0], last_p[1]}, 8'h3B);
    chk(last_a[0] == 16'd2 && last_a[1] == 16'd2, "R7 halfword addresses",
        {last_a[0], last_a[1]}, {16'd2, 16'd2});

    // R5 R7 8-bit memory
    cfg(0, 2'b00, 2'b10);
    e = exp_rd(0, 1, 2);
    go(0, 0, 16'h0001, 0, e, 4, "R7 four byte cycles");
    chk(last_p[0] == 4'b0001 && last_p[1] == 4'b0101 && last_p[2] == 4'b1001 && last_p[3] == 4'b1101,
        "R5 byte select order", {last_p[0], last_p[1], last_p[2], last_p[3]}, 16'h159D);
    for (int i = 8; i < 12; i++) sm[0][i] = 8'(32'h11223344 >> (8 * (i - 8)));
    go(0, 1, 16'h0002, 32'h1122_3344, 0, 4, "R7 four byte write");
    for (int i = 8; i < 12; i++) chk(bm[0][i] == sm[0][i], "R8 byte write image", 32'(bm[0][i]), 32'(sm[0][i]));
    chk(bm[0][12] == sm[0][12], "R8 neighbour untouched", 32'(bm[0][12]), 32'(sm[0][12]));
    e = exp_rd(0, 2, 2);
    go(0, 0, 16'h0002, 0, e, 4, "R7 readback assembly");
    cfg(0, 2'b00, 2'b01);
    e = exp_rd(0, 3, 1);
    go(0, 0, 16'h0003, 0, e, 2, "R7 halfword from 8-bit memory");
    chk(last_p[0] == 4'b1001 && last_p[1] == 4'b1101, "R5 bytes 2 and 3", {last_p[0], last_p[1]}, 8'h9D);

    // R9 reserved code acts as 32
    cfg(1, 2'b11, 2'b11);
    e = exp_rd(1, 4, 2);
    go(0, 0, 16'h8004, 0, e, 1, "R9 reserved code read");
    chk(last_p[0] == 4'b1111, "R9 full lanes", 32'(last_p[0]), 32'hF);

    // R11 reconfiguration takes effect
    cfg(0, 2'b10, 2'b10);
    e = exp_rd(0, 1, 2);
    go(0, 0, 16'h0001, 0, e, 1, "R11 word before change");
    cfg(0, 2'b10, 2'b00);
    e = exp_rd(0, 1, 0);
    go(0, 0, 16'h0001, 0, e, 1, "R11 byte after change");

    // R10 program fetch
    prg_16 = 0;
    go(1, 0, 16'h0003, 0, {phw[7], phw[6]}, 1, "R10 32-bit fetch");
    chk(last_a[0] == 16'd3 && last_reg == 3'b100, "R10 single fetch address", 32'(last_a[0]), 3);
    prg_16 = 1;
    go(1, 0, 16'h0003, 0, {phw[7], phw[6]}, 2, "R10 16-bit fetch");
    chk(last_a[0] == 16'd6 && last_a[1] == 16'd7, "R10 halfword addresses",
        {last_a[0], last_a[1]}, {16'd6, 16'd7});
    chk(last_reg == 3'b100, "R2 fetch uses program select", 32'(last_reg), 4);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results seen", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule